// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It sequences three analog switches around an external integrator: one clears the integrator, one connects the unknown input, and one connects the reference of opposite sign. It then measures how long the reference takes to bring the integrator back through zero. The integration time of the input is fixed at 2^CODE_W clocks. As a result, the run-down count is directly the CODE_W-bit conversion code: the input equals the reference times the run-down count divided by the fixed integration time.

A conversion is requested with a one-clock start pulse while the block is idle. The sequence has four phases. The integrator is first cleared for a programmable number of clocks. The input is then integrated for exactly 2^CODE_W clocks. After one clock with every switch open, the reference is integrated while a counter runs. The run-down ends when the zero-crossing comparator reports that the integrator has gone below zero. If no crossing arrives before the count reaches its largest value, the conversion ends as overrange with a saturated code. Either way, the result is latched and announced with a single-clock done pulse.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is asserted and after its release, all three switch controls, busy, done, overrange and the result are 0.
- R2: A start sampled high while idle raises busy and the integrator-clear control on the next clock. The clear control stays closed for exactly RST_CYC clocks. The input control then stays closed for exactly 2^CODE_W clocks.
- R3: The input and reference controls are never high in the same clock. Exactly one clock with all three controls low separates the input phase from the reference phase.
- R4: The run-down counter is zero on the clock the reference control closes and advances once per run-down clock. At the first edge where the comparator (cmp_neg_i, 1 = integrator below zero) is sampled high, the result becomes the count value, the reference control opens, and the reference has been closed for result+1 clocks.
- R5: With an integrator that adds Vin per input clock and subtracts Vref per reference clock, the result equals floor(2^CODE_W × Vin / Vref) whenever that value is at most 2^CODE_W−1.
- R6: If the comparator is still low at the edge where the count equals 2^CODE_W−1, the conversion ends with the overrange flag at 1 and the result at all ones, after 2^CODE_W reference clocks.
- R7: If the comparator goes high at the same edge where the count reaches 2^CODE_W−1, the crossing wins: the result is all ones with the overrange flag at 0.
- R8: Done is high for exactly one clock. In that clock busy is already 0 and the new result and overrange flag are visible. Both then hold their values until the next done.
- R9: A start seen while busy, including the edge at which the conversion finishes, is ignored. It changes neither the phase timing nor the result, and it does not begin a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_neg_i | input | 1 | Zero-crossing comparator, 1 when the integrator is below zero |
| int_rst_o | output | 1 | Closes the integrator-clear switch |
| in_sel_o | output | 1 | Closes the input switch |
| ref_sel_o | output | 1 | Closes the reference switch |
| result_o | output | CODE_W | Latched conversion code |
| done_o | output | 1 | One-clock pulse when a result is latched |
| busy_o | output | 1 | High while a conversion is in progress |
| ovr_o | output | 1 | Latched overrange flag, valid with the result |

## Verification
The zero crossing and the run-down timeout can fall on the same clock edge, because the comparator can first go high exactly when the counter sits at its largest value. This is provoked with an input of 255/256 of the reference: the integrator then first goes negative on the 256th reference clock. The bench judges the conversion by the overrange flag, which must stay 0, and by the code, which must be all ones. A second coincidence, a start held high through the finishing edge, is judged by the block staying idle afterwards.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ZERO,
        PH_INTEG,
        PH_GAP,
        PH_RUNDN
    } phase_e;

    typedef struct packed {
        logic zero;
        logic sig;
        logic vref;
    } sw_t;

endpackage

// File: rtl/dss_step_counter.sv
module dss_step_counter #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/dss_switch_drive.sv
module dss_switch_drive
    import dss_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  phase_e phase_d_i,
    output logic   zero_o,
    output logic   sig_o,
    output logic   vref_o
);

    sw_t sw_d, sw_q;

    // Switch states are registered from the next phase, so each control
    // changes only on a clock edge and never through combinational logic.
    always_comb begin
        sw_d      = '0;
        sw_d.zero = (phase_d_i == PH_ZERO);
        sw_d.sig  = (phase_d_i == PH_INTEG);
        sw_d.vref = (phase_d_i == PH_RUNDN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sw_q <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign zero_o = sw_q.zero;
    assign sig_o  = sw_q.sig;
    assign vref_o = sw_q.vref;

    // R3: input and reference never closed together
    assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sw_q.sig && sw_q.vref));

    // R3: the clock before the reference closes has every switch open
    assert_dead_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sw_q.vref) |-> $past(!sw_q.sig && !sw_q.zero));

    // R3: the clear switch is never closed together with the reference
    assert_clear_vs_ref_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_q.zero |-> !sw_q.vref);

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dss_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int RST_CYC = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              cmp_neg_i,
    output logic              int_rst_o,
    output logic              in_sel_o,
    output logic              ref_sel_o,
    output logic [CODE_W-1:0] result_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              ovr_o
);

    localparam logic [CODE_W-1:0] RST_LAST   = CODE_W'(RST_CYC - 1);
    localparam logic [CODE_W-1:0] INTEG_LAST = '1;  // 2^CODE_W clocks
    localparam logic [CODE_W-1:0] CNT_MAX    = '1;

    typedef struct packed {
        phase_e            phase;
        logic              busy;
        logic              done;
        logic              ovr;
        logic [CODE_W-1:0] res;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic cnt_clr, cnt_inc;
    logic [CODE_W-1:0] cnt;

    dss_step_counter #(.W(CODE_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .cnt_o  (cnt)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                cnt_clr = 1'b1;
                if (start_i) begin
                    ctl_d.phase = PH_ZERO;
                    ctl_d.busy  = 1'b1;
                end
            end
            PH_ZERO: begin
                if (cnt == RST_LAST) begin
                    ctl_d.phase = PH_INTEG;
                    cnt_clr     = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            PH_INTEG: begin
                if (cnt == INTEG_LAST) begin
                    ctl_d.phase = PH_GAP;
                    cnt_clr     = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            PH_GAP: begin
                ctl_d.phase = PH_RUNDN;
                cnt_clr     = 1'b1;
            end
            PH_RUNDN: begin
                if (cmp_neg_i) begin
                    // zero crossing has priority over the timeout
                    ctl_d.phase = PH_IDLE;
                    ctl_d.busy  = 1'b0;
                    ctl_d.done  = 1'b1;
                    ctl_d.ovr   = 1'b0;
                    ctl_d.res   = cnt;
                    cnt_clr     = 1'b1;
                end else if (cnt == CNT_MAX) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.busy  = 1'b0;
                    ctl_d.done  = 1'b1;
                    ctl_d.ovr   = 1'b1;
                    ctl_d.res   = '1;
                    cnt_clr     = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: begin
                ctl_d.phase = PH_IDLE;
                ctl_d.busy  = 1'b0;
                cnt_clr     = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{phase: PH_IDLE, busy: 1'b0, done: 1'b0, ovr: 1'b0, res: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dss_switch_drive u_sw (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .phase_d_i (ctl_d.phase),
        .zero_o    (int_rst_o),
        .sig_o     (in_sel_o),
        .vref_o    (ref_sel_o)
    );

    assign result_o = ctl_q.res;
    assign done_o   = ctl_q.done;
    assign busy_o   = ctl_q.busy;
    assign ovr_o    = ctl_q.ovr;

    // R4: the run-down counter starts from zero as the reference closes
    assert_count_from_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ref_sel_o) |-> (cnt == '0));

    // R6: an overrange result is always saturated
    assert_ovr_saturated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_o |-> (result_o == CNT_MAX));

    // R8: done lasts a single clock and busy is already low with it
    assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R8: the result only moves together with done
    assert_result_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(result_o) && $stable(ovr_o)));

    // R9: once past the clear phase, a running conversion never restarts
    assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !int_rst_o) |=> !int_rst_o);

endmodule

// File: tb/dual_slope_seq_bench.sv
module dual_slope_seq_bench;

    localparam int  CODE_W  = 8;
    localparam int  RST_CYC = 4;
    localparam int  T1      = 1 << CODE_W;
    localparam int  CMAX    = T1 - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp;
    logic int_rst, in_sel, ref_sel, done, busy, ovr;
    logic [CODE_W-1:0] result;

    longint acc = 0;
    longint vin_m = 0;
    longint vref_m = 256;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dual_slope_seq #(.CODE_W(CODE_W), .RST_CYC(RST_CYC)) u_dual_slope_seq (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .cmp_neg_i (cmp),
        .int_rst_o (int_rst),
        .in_sel_o  (in_sel),
        .ref_sel_o (ref_sel),
        .result_o  (result),
        .done_o    (done),
        .busy_o    (busy),
        .ovr_o     (ovr)
    );

    // Integrator model: one step per clock of switch closure.
    always @(negedge clk) begin
        if (int_rst)      acc <= 0;
        else if (in_sel)  acc <= acc + vin_m;
        else if (ref_sel) acc <= acc - vref_m;
    end
    assign cmp = (acc < 0);

    task automatic check_eq(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // One conversion; hold=1 keeps start high until done (start while busy).
    task automatic run_conv(longint vin, longint vref, bit hold, string tag);
        longint q, exp_res, exp_ovr;
        int nz = 0, ni = 0, nr = 0, overlap = 0, ngap = 0;
        bit seen_done = 1'b0;
        logic [CODE_W-1:0] res_at_done;
        logic ovr_at_done;
        vin_m  = vin;
        vref_m = vref;
        q = (T1 * vin) / vref;
        exp_res = (q > CMAX) ? CMAX : q;
        exp_ovr = (q > CMAX) ? 1 : 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        check_eq({tag, " R2 busy after start"}, busy, 1);
        check_eq({tag, " R2 clear closed after start"}, int_rst, 1);
        for (int i = 0; i < 4000; i++) begin
            nz += int_rst;
            ni += in_sel;
            nr += ref_sel;
            if (in_sel && ref_sel) overlap++;
            if (busy && !int_rst && !in_sel && !ref_sel && ni > 0 && nr == 0) ngap++;
            if (done) begin
                seen_done = 1'b1;
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        res_at_done = result;
        ovr_at_done = ovr;
        check_eq({tag, " R8 done seen"}, seen_done, 1);
        check_eq({tag, " R8 busy low with done"}, busy, 0);
        check_eq({tag, " R5 result"}, res_at_done, exp_res);
        check_eq({tag, " R6 overrange flag"}, ovr_at_done, exp_ovr);
        check_eq({tag, " R2 clear clocks"}, nz, RST_CYC);
        check_eq({tag, " R2 input clocks"}, ni, T1);
        check_eq({tag, " R3 overlap clocks"}, overlap, 0);
        check_eq({tag, " R3 dead clocks"}, ngap, 1);
        check_eq({tag, " R4 reference clocks"}, nr, exp_res + 1);
        @(negedge clk);
        check_eq({tag, " R8 done one clock"}, done, 0);
        check_eq({tag, " R8 result held"}, result, res_at_done);
        check_eq({tag, " R8 flag held"}, ovr, ovr_at_done);
        if (hold) begin
            check_eq({tag, " R9 no restart busy"}, busy, 0);
            check_eq({tag, " R9 no restart clear"}, int_rst, 0);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_eq("R1 clear in reset", int_rst, 0);
        check_eq("R1 input in reset", in_sel, 0);
        check_eq("R1 reference in reset", ref_sel, 0);
        check_eq("R1 busy in reset", busy, 0);
        check_eq("R1 done in reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1 result after reset", result, 0);
        check_eq("R1 flag after reset", ovr, 0);
        check_eq("R1 busy after reset", busy, 0);
    endtask

    task automatic test_zero_input();
        run_conv(0, 256, 1'b0, "zero");
    endtask

    task automatic test_midscale();
        run_conv(100, 256, 1'b0, "mid");
    endtask

    task automatic test_fraction();
        // floor(256*77/200) = 98 (R5)
        run_conv(77, 200, 1'b0, "ratio");
    endtask

    task automatic test_coincide();
        // crossing lands on the timeout edge: code 255, flag 0 (R7)
        run_conv(255, 256, 1'b0, "R7 coincide");
    endtask

    task automatic test_overrange();
        run_conv(300, 256, 1'b0, "R6 over");
    endtask

    task automatic test_start_busy();
        run_conv(50, 256, 1'b1, "R9 hold");
    endtask

    task automatic test_after_over();
        // flag must clear on a normal conversion after an overrange one
        run_conv(256, 256, 1'b0, "R6 edge");
        run_conv(10, 256, 1'b0, "R8 recover");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        test_reset();
        test_zero_input();
        test_midscale();
        test_fraction();
        test_coincide();
        test_overrange();
        test_start_busy();
        test_after_over();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule